// File: doc/BRIEF.md
# Standard Event Status Register Unit

This block keeps the latched event status of an instrument-style status reporting scheme. A set of single-cycle strobes, one per defined event, sets sticky bits in an 8-bit event register. An 8-bit enable mask selects which latched events drive a summary bit. The block also carries a configurable number of auxiliary event registers. Each one has its own enable mask and its own summary bit in the status byte. The status byte output also passes through a message-available bit from an input, which the block never changes.

Software reaches the block through a small register port. A write loads an enable mask. A read of a mask returns the last value written. A read of an event register returns its contents and clears it in the same step. A clear-status pulse empties every event register, and so drops their summary bits. It leaves the masks and the message-available bit alone. While a system-error flag is raised, clear-status and destructive reads still work, but mask writes are refused.

Top module: `esr_unit`

## Requirements
- R1: After reset, the standard event register holds 0x80 (power-on, bit 7) and every other bit is 0. Every auxiliary event register holds 0, every enable mask holds 0, and the status byte holds only the message-available bit.
- R2: Any mask value 0 to 255 written at address 0 reads back unchanged from address 0 in the next read.
- R3: Standard event bits 6 (user request) and 1 (request control) never latch, whatever the strobes or the mask hold. The other bits, from 7 down, are power-on, (6), command error, execution error, device error, query error, (1) and operation complete.
- R4: A latched event bit stays set across idle cycles and further strobes until a destructive read or a clear-status pulse.
- R5: A read of address 1 returns the standard event register on reg_rdata_o one clock after the read strobe and clears the register. A second read returns 0.
- R6: A clear-status pulse zeroes the standard register and all auxiliary event registers. Status byte bit 5 and auxiliary summary bits 0..N_AUX-1 go low.
- R7: Clear-status leaves every enable mask unchanged. Status byte bit 4 always equals mav_i.
- R8: An event strobe in the same cycle as a destructive read or clear-status stays latched, and the read returns the value held before that cycle.
- R9: Status byte bit 5 is the OR of (standard events AND standard mask). Bit k (k < N_AUX) is the same for auxiliary register k, whose mask is at address 2+2k and whose events are at 3+2k. Bits 7 and 6, and unused low bits, are 0.
- R10: While sys_err_i is 1, mask writes have no effect, but clear-status and destructive reads work as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| std_evt_i | input | 8 | Single-cycle strobes for standard events, bit 7 power-on |
| aux_evt_i | input | 8*N_AUX | Strobes for the auxiliary event registers, byte k for register k |
| clr_i | input | 1 | Clear-status pulse |
| sys_err_i | input | 1 | System-error flag, blocks mask writes |
| mav_i | input | 1 | Message-available bit placed in status byte bit 4 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (destructive at event addresses) |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid the cycle after reg_rd_i |
| stb_o | output | 8 | Status byte summary bits |

## Verification
On every cycle the assertions check several rules: the two dead bit positions stay zero, latched bits persist unless wiped, a fresh strobe survives a wipe, masks hold unless written, and mask writes are locked out under system error. Only the bench's scenarios can show the rest. These are the full mask readback sweep, the mapping of each event position and mask value to the summary bits, and that clear-status spares the masks and message-available bit. They also include the read-old-value ordering when a strobe meets a read, and the lockout of writes seen from the register port.

// File: rtl/esr_pkg.sv
package esr_pkg;
   localparam int ESR_W = 8;

   // Standard event bit positions
   localparam int EB_DONE      = 0;
   localparam int EB_BUSREQ    = 1;
   localparam int EB_QUERY_ERR = 2;
   localparam int EB_DEV_ERR   = 3;
   localparam int EB_EXEC_ERR  = 4;
   localparam int EB_CMD_ERR   = 5;
   localparam int EB_USER      = 6;
   localparam int EB_POWER     = 7;

   // Status byte positions
   localparam int SB_MAV = 4;
   localparam int SB_STD = 5;

   localparam logic [ESR_W-1:0] STD_DEAD = ESR_W'((1 << EB_USER) | (1 << EB_BUSREQ));
   localparam logic [ESR_W-1:0] STD_INIT = ESR_W'(1 << EB_POWER);

   localparam int ADDR_STD_MASK = 0;
   localparam int ADDR_STD_EV   = 1;
endpackage

// File: rtl/esr_event_reg.sv
module esr_event_reg #(
   parameter int                W      = 8,
   parameter logic [W-1:0]      DEAD   = '0,
   parameter logic [W-1:0]      INIT   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         wipe_i,
   output logic [W-1:0] q_o
);
   localparam logic [W-1:0] LIVE = ~DEAD;

   logic [W-1:0] q;
   logic [W-1:0] keep;
   logic [W-1:0] nxt;

   generate
      if (W < 1) begin : g_bad_w
         $error("esr_event_reg: W must be at least 1");
      end
   endgenerate

   // Per-bit next state, dead positions tied off structurally
   generate
      for (genvar b = 0; b < W; b++) begin : g_bit
         if (DEAD[b]) begin : g_dead
            assign nxt[b] = 1'b0;
         end else begin : g_live
            assign keep[b] = q[b] & ~wipe_i;
            assign nxt[b]  = keep[b] | set_i[b];
         end
         if (DEAD[b]) begin : g_keep0
            assign keep[b] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= INIT & LIVE;
      else        q <= nxt;
   end

   assign q_o = q;

   AST_DEAD_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (q & DEAD) == '0);  // R3
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !wipe_i |=> ((q & $past(q)) == $past(q)));  // R4
   AST_WIPE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (wipe_i && set_i == '0) |=> (q == '0));  // R5
   AST_NEW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_i & LIVE) != '0) |=> ((q & $past(set_i & LIVE)) == $past(set_i & LIVE)));  // R8
endmodule

// File: rtl/esr_mask_reg.sv
module esr_mask_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (we_i) q <= d_i;
   end

   assign q_o = q;

   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(q));  // R7
   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (q == $past(d_i)));  // R2
endmodule

// File: rtl/esr_summary.sv
module esr_summary #(
   parameter int W = 8
) (
   input  logic [W-1:0] ev_i,
   input  logic [W-1:0] mask_i,
   output logic         hit_o
);
   logic [W-1:0] both;
   assign both  = ev_i & mask_i;
   assign hit_o = |both;
endmodule

// File: rtl/esr_unit.sv
module esr_unit
   import esr_pkg::*;
#(
   parameter int             N_AUX    = 2,
   parameter logic [7:0]     AUX_DEAD = 8'h00,
   localparam int            N_REG    = 2 * (N_AUX + 1),
   localparam int            ADDR_W   = (N_REG > 2) ? $clog2(N_REG) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ESR_W-1:0]      std_evt_i,
   input  logic [8*N_AUX-1:0]    aux_evt_i,
   input  logic                  clr_i,
   input  logic                  sys_err_i,
   input  logic                  mav_i,
   input  logic                  reg_wr_i,
   input  logic                  reg_rd_i,
   input  logic [ADDR_W-1:0]     reg_addr_i,
   input  logic [ESR_W-1:0]      reg_wdata_i,
   output logic [ESR_W-1:0]      reg_rdata_o,
   output logic [ESR_W-1:0]      stb_o
);
   generate
      if (N_AUX < 1 || N_AUX > 4) begin : g_bad_aux
         $error("esr_unit: N_AUX must be in 1..4 (summary bits 0..3)");
      end
   endgenerate

   logic [ESR_W-1:0] std_ev, std_mask;
   logic             std_hit, std_we, std_wipe;
   logic             wr_ok;
   logic [ESR_W-1:0] aux_ev   [N_AUX];
   logic [ESR_W-1:0] aux_mask [N_AUX];
   logic [N_AUX-1:0] aux_hit;
   logic [ESR_W-1:0] rd_mux;
   logic [ESR_W-1:0] rdata_q;

   assign wr_ok    = reg_wr_i & ~sys_err_i;
   assign std_we   = wr_ok & (reg_addr_i == ADDR_W'(ADDR_STD_MASK));
   assign std_wipe = clr_i | (reg_rd_i & (reg_addr_i == ADDR_W'(ADDR_STD_EV)));

   esr_event_reg #(.W(ESR_W), .DEAD(STD_DEAD), .INIT(STD_INIT)) u_std_ev (
      .clk(clk), .rst_n(rst_n), .set_i(std_evt_i), .wipe_i(std_wipe), .q_o(std_ev));

   esr_mask_reg #(.W(ESR_W)) u_std_mask (
      .clk(clk), .rst_n(rst_n), .we_i(std_we), .d_i(reg_wdata_i), .q_o(std_mask));

   esr_summary #(.W(ESR_W)) u_std_sum (
      .ev_i(std_ev), .mask_i(std_mask), .hit_o(std_hit));

   generate
      for (genvar k = 0; k < N_AUX; k++) begin : g_aux
         localparam int A_MASK = 2 + 2 * k;
         localparam int A_EV   = 3 + 2 * k;
         logic we_k, wipe_k;
         assign we_k   = wr_ok & (reg_addr_i == ADDR_W'(A_MASK));
         assign wipe_k = clr_i | (reg_rd_i & (reg_addr_i == ADDR_W'(A_EV)));

         esr_event_reg #(.W(ESR_W), .DEAD(AUX_DEAD), .INIT('0)) u_ev (
            .clk(clk), .rst_n(rst_n), .set_i(aux_evt_i[8*k +: 8]),
            .wipe_i(wipe_k), .q_o(aux_ev[k]));

         esr_mask_reg #(.W(ESR_W)) u_mask (
            .clk(clk), .rst_n(rst_n), .we_i(we_k), .d_i(reg_wdata_i), .q_o(aux_mask[k]));

         esr_summary #(.W(ESR_W)) u_sum (
            .ev_i(aux_ev[k]), .mask_i(aux_mask[k]), .hit_o(aux_hit[k]));
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      if (reg_addr_i == ADDR_W'(ADDR_STD_MASK)) rd_mux = std_mask;
      if (reg_addr_i == ADDR_W'(ADDR_STD_EV))   rd_mux = std_ev;
      for (int k = 0; k < N_AUX; k++) begin
         if (reg_addr_i == ADDR_W'(2 + 2 * k)) rd_mux = aux_mask[k];
         if (reg_addr_i == ADDR_W'(3 + 2 * k)) rd_mux = aux_ev[k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata_q <= '0;
      else if (reg_rd_i) rdata_q <= rd_mux;
   end
   assign reg_rdata_o = rdata_q;

   always_comb begin
      stb_o         = '0;
      stb_o[SB_MAV] = mav_i;
      stb_o[SB_STD] = std_hit;
      for (int k = 0; k < N_AUX; k++) stb_o[k] = aux_hit[k];
   end

   AST_READ_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd_i && reg_addr_i == ADDR_W'(ADDR_STD_EV)) |=> (reg_rdata_o == $past(std_ev)));  // R5
   AST_ERR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      sys_err_i |=> (std_mask == $past(std_mask)));  // R10
   AST_CLR_DROPS_SUM: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && std_evt_i == '0) |=> !stb_o[SB_STD]);  // R6
endmodule

// File: tb/sim_esr_unit.sv
module sim_esr_unit;
   localparam int N_AUX = 2;
   localparam int AW    = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [7:0]       std_evt = '0;
   logic [15:0]      aux_evt = '0;
   logic             clr = 1'b0, sys_err = 1'b0, mav = 1'b0;
   logic             wr = 1'b0, rd = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic [7:0]       wdata = '0;
   logic [7:0]       rdata, stb;

   int total = 0, fails = 0;
   logic [7:0] got;

   always #4 clk = ~clk;

   esr_unit #(.N_AUX(N_AUX)) u0 (
      .clk(clk), .rst_n(rst_n), .std_evt_i(std_evt), .aux_evt_i(aux_evt),
      .clr_i(clr), .sys_err_i(sys_err), .mav_i(mav), .reg_wr_i(wr), .reg_rd_i(rd),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .stb_o(stb));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wreg(input int a, input logic [7:0] d);
      @(negedge clk); wr = 1'b1; addr = AW'(a); wdata = d;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rreg(input int a, output logic [7:0] v);
      @(negedge clk); rd = 1'b1; addr = AW'(a);
      @(negedge clk); rd = 1'b0; v = rdata;
   endtask

   task automatic pulse(input logic [7:0] s, input logic [15:0] x);
      @(negedge clk); std_evt = s; aux_evt = x;
      @(negedge clk); std_evt = '0; aux_evt = '0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   initial begin
      #1_000_000;
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 stb", stb, 8'h00);
      rreg(0, got); chk("R1 std mask", got, 8'h00);
      rreg(2, got); chk("R1 aux0 mask", got, 8'h00);
      rreg(5, got); chk("R1 aux1 ev", got, 8'h00);
      rreg(1, got); chk("R1 std ev power-on", got, 8'h80);

      // R2 full mask sweep
      for (int m = 0; m < 256; m++) begin
         wreg(0, 8'(m));
         rreg(0, got); chk("R2 mask readback", got, 8'(m));
      end

      // R3 per-bit latch map, R9 summary with mask 0xFF
      wreg(0, 8'hFF);
      for (int b = 0; b < 8; b++) begin
         logic [7:0] e;
         e = 8'(1 << b) & 8'hBD;
         pulse(8'(1 << b), '0);
         chk("R9 std summary per bit", stb & 8'h20, (e != 0) ? 8'h20 : 8'h00);
         rreg(1, got); chk("R3 latch map", got, e);
      end
      pulse(8'hFF, '0);
      rreg(1, got); chk("R3 all strobes", got, 8'hBD);

      // R4 sticky
      pulse(8'h01, '0);
      repeat (5) @(negedge clk);
      pulse(8'h08, '0);
      rreg(1, got); chk("R4 sticky", got, 8'h09);
      rreg(1, got); chk("R5 second read empty", got, 8'h00);

      // R9 mask sweep against fixed events
      pulse(8'h24, '0);
      for (int m = 0; m < 256; m++) begin
         wreg(0, 8'(m));
         chk("R9 std summary sweep", stb, ((8'(m) & 8'h24) != 0) ? 8'h20 : 8'h00);
      end
      rreg(1, got); chk("R5 read returns", got, 8'h24);
      chk("R5 summary dropped", stb, 8'h00);

      // R9 auxiliary summaries
      wreg(0, 8'h00);
      pulse('0, 16'h0005);
      for (int m = 0; m < 16; m++) begin
         wreg(2, 8'(m));
         chk("R9 aux summary", stb, ((8'(m) & 8'h05) != 0) ? 8'h01 : 8'h00);
      end
      wreg(4, 8'hFF);
      pulse('0, 16'h8000);
      chk("R9 aux1 summary", stb, 8'h03);

      // R6 / R7 clear-status
      wreg(0, 8'h30);
      pulse(8'h10, '0);
      mav = 1'b1;
      @(negedge clk);
      chk("R7 mav passthrough", stb, 8'h33);
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      chk("R6 summaries cleared, R7 mav kept", stb, 8'h10);
      rreg(0, got); chk("R7 std mask kept", got, 8'h30);
      rreg(2, got); chk("R7 aux0 mask kept", got, 8'h0F);
      rreg(4, got); chk("R7 aux1 mask kept", got, 8'hFF);
      rreg(1, got); chk("R6 std ev cleared", got, 8'h00);
      rreg(3, got); chk("R6 aux0 ev cleared", got, 8'h00);
      rreg(5, got); chk("R6 aux1 ev cleared", got, 8'h00);
      mav = 1'b0;

      // R8 strobe meets read / clear
      pulse(8'h04, '0);
      @(negedge clk); std_evt = 8'h10; rd = 1'b1; addr = AW'(1);
      @(negedge clk); std_evt = '0; rd = 1'b0; got = rdata;
      chk("R8 read returns old", got, 8'h04);
      rreg(1, got); chk("R8 new event kept after read", got, 8'h10);
      @(negedge clk); std_evt = 8'h20; clr = 1'b1;
      @(negedge clk); std_evt = '0; clr = 1'b0;
      rreg(1, got); chk("R8 new event kept after clear", got, 8'h20);

      // R10 system error
      sys_err = 1'b1;
      wreg(0, 8'hAA);
      rreg(0, got); chk("R10 mask write refused", got, 8'h30);
      pulse(8'h20, 16'h0101);
      rreg(1, got); chk("R10 read works", got, 8'h20);
      rreg(1, got); chk("R10 read cleared", got, 8'h00);
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      rreg(3, got); chk("R10 clear works", got, 8'h00);
      sys_err = 1'b0;
      wreg(0, 8'h55);
      rreg(0, got); chk("R10 write after error", got, 8'h55);

      summary();
      $finish;
   end
endmodule